// File: doc/BRIEF.md
# Load-Use Interlock Bubble Controller

This block sits at the boundary between the decode and execute stages of an in-order RISC pipeline. A load or a special-register read that is in execute cannot hand its result to the very next instruction, because that value first appears at the end of the memory stage. Each cycle the controller compares the destination of such a producer with the source registers that the decode-stage instruction actually reads. When they match, the controller sends a no-op bubble into execute and tells decode to hold its instruction. Three kinds of consumer are covered in the same way: ALU operations, the start of a multi-cycle divide, and register-indirect jumps.

The controller is a three-state machine. **PASS** is the normal state: instructions flow through, and a detected hazard raises the bubble and takes the transition *PASS→WAIT*. **WAIT** keeps the bubble and the hold asserted for as long as the producer sits in the memory stage, including every cycle in which that stage stalls. The cycle in which the memory stage reports valid data and no stall takes the transition *WAIT→RELEASE*. **RELEASE** issues the held instruction for one cycle, and the instruction picks up the value by forwarding from writeback. It then takes *RELEASE→PASS*. A branch flush takes *any→PASS*, which discards the held instruction and any further bubbles. The release is a registered decision, so the jump-issue output has no combinational path from the memory-stage stall.

Top module: `hb_bubble_ctrl`

## Requirements
- R1: A hazard exists when decode is valid, execute holds a valid load or special-register read, and that producer's destination equals a source register the decode instruction reads. In that cycle `bubble_o`=1, `hold_o`=1 and `issue_o`=0.
- R2: A special-register read (`ex_is_spr_rd`) produces exactly the same interlock as a load (`ex_is_load`).
- R3: A producer whose destination is register 0 never causes a hazard.
- R4: A source takes part in the comparison only when its read flag is set. For `dec_kind`=2'b10 (register-indirect jump) only source B, the jump target, is compared and source A is ignored.
- R5: In WAIT, every cycle in which the memory stage stalls gives `bubble_o`=1, `hold_o`=1 and `issue_o`=0 in the cycle that follows.
- R6: The cycle after the memory stage shows `mem_valid`=1 and `mem_stall`=0 while in WAIT, `issue_o`=1, `bubble_o`=0 and `hold_o`=0. In the cycle after that, the controller is back in PASS.
- R7: `div_start_o` equals `issue_o` for `dec_kind`=2'b01 (divide) and `jump_go_o` equals `issue_o` for `dec_kind`=2'b10. A held divide or jump raises neither of these until its release. Kinds are 2'b00 ALU and 2'b11 other.
- R8: In a cycle with `flush`=1, `issue_o` and `bubble_o` are both 0. The held instruction is dropped, and the next cycle is handled in PASS.
- R9: In RELEASE, `jump_go_o` does not change when `mem_stall` changes within the cycle.
- R10: With no hazard in PASS, `issue_o` follows `dec_valid` in the same cycle and `bubble_o`=0.
- R11: After reset, with `dec_valid`=0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Branch flush of the front stages |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_kind | input | 2 | 00 ALU, 01 divide, 10 register jump, 11 other |
| dec_src_a | input | RW | Source A register index |
| dec_rd_a | input | 1 | Source A is read from the register file |
| dec_src_b | input | RW | Source B / jump target register index |
| dec_rd_b | input | 1 | Source B is read from the register file |
| ex_valid | input | 1 | Execute holds a valid instruction |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_spr_rd | input | 1 | Execute instruction reads a special register |
| ex_dst | input | RW | Destination register of the execute instruction |
| mem_valid | input | 1 | Memory stage holds a valid instruction |
| mem_stall | input | 1 | Memory stage is stalling |
| issue_o | output | 1 | Real decode instruction enters execute |
| bubble_o | output | 1 | No-op enters execute |
| hold_o | output | 1 | Decode must keep its instruction |
| div_start_o | output | 1 | Divider may start |
| jump_go_o | output | 1 | Register-indirect jump may be taken |

## Verification
Several properties are checked on every cycle by the assertions. Issue and bubble never rise together. A start signal never appears without an issue. A register-0 destination never produces a hit. The transitions also hold: a hazard or a stall in WAIT is followed by no issue, a completing memory stage is followed by an issue, and a flush is followed by PASS. The exact sequences need the directed scenarios: the bubble run across a multi-cycle stall, the one-cycle release, the operand-selection rules per instruction kind, the equivalence of the two producer types, and the jump output held steady while the stall toggles.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        KIND_ALU   = 2'b00,
        KIND_DIV   = 2'b01,
        KIND_JREG  = 2'b10,
        KIND_OTHER = 2'b11
    } hb_kind_e;

    typedef enum logic [1:0] {
        ST_PASS    = 2'b00,
        ST_WAIT    = 2'b01,
        ST_RELEASE = 2'b10
    } hb_state_e;

    localparam int unsigned HB_NSRC = 2;
endpackage

// File: rtl/hb_dep_match.sv
module hb_dep_match #(
    parameter int unsigned RW   = 5,
    parameter int unsigned NSRC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prod_live,
    input  logic [RW-1:0]       prod_dst,
    input  logic [NSRC*RW-1:0]  src_idx,
    input  logic [NSRC-1:0]     src_rd,
    output logic                hit
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] per_src;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_cmp
            assign per_src[g] = src_rd[g] && (src_idx[g*RW +: RW] == prod_dst);
        end
    endgenerate

    assign hit = prod_live && (prod_dst != ZERO_REG) && (|per_src);

    // R3
    r0_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_dst == ZERO_REG) |-> !hit);
endmodule

// File: rtl/hb_seq_fsm.sv
module hb_seq_fsm
    import hb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     hazard,
    input  logic     dec_valid,
    input  logic [1:0] dec_kind,
    input  logic     mem_valid,
    input  logic     mem_stall,
    output logic     issue_o,
    output logic     bubble_o,
    output logic     hold_o,
    output logic     div_start_o,
    output logic     jump_go_o
);
    hb_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PASS;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PASS:    if (!flush && hazard) state_nx = ST_WAIT;
            ST_WAIT:    if (flush) state_nx = ST_PASS;
                        else if (mem_valid && !mem_stall) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = ST_PASS;
            default:    state_nx = ST_PASS;
        endcase
    end

    always_comb begin
        issue_o  = 1'b0;
        bubble_o = 1'b0;
        hold_o   = 1'b0;
        unique case (state)
            ST_PASS: begin
                issue_o  = dec_valid && !hazard && !flush;
                bubble_o = hazard && !flush;
                hold_o   = hazard && !flush;
            end
            ST_WAIT: begin
                bubble_o = !flush;
                hold_o   = !flush;
            end
            ST_RELEASE: issue_o = !flush;
            default: ;
        endcase
        div_start_o = issue_o && (dec_kind == KIND_DIV);
        jump_go_o   = issue_o && (dec_kind == KIND_JREG);
    end

    // R1
    hazard_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && hazard && !flush) |=> !issue_o);
    // R5
    stall_keeps_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mem_stall && !flush) |=> (!issue_o && (bubble_o || flush)));
    // R6
    release_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mem_valid && !mem_stall && !flush) |=> (issue_o || flush));
    // R8
    flush_to_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == ST_PASS));
    // R1
    issue_bubble_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_o && bubble_o));
endmodule

// File: rtl/hb_bubble_ctrl.sv
module hb_bubble_ctrl
    import hb_pkg::*;
#(
    parameter int unsigned RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          dec_valid,
    input  logic [1:0]    dec_kind,
    input  logic [RW-1:0] dec_src_a,
    input  logic          dec_rd_a,
    input  logic [RW-1:0] dec_src_b,
    input  logic          dec_rd_b,
    input  logic          ex_valid,
    input  logic          ex_is_load,
    input  logic          ex_is_spr_rd,
    input  logic [RW-1:0] ex_dst,
    input  logic          mem_valid,
    input  logic          mem_stall,
    output logic          issue_o,
    output logic          bubble_o,
    output logic          hold_o,
    output logic          div_start_o,
    output logic          jump_go_o
);
    logic                    prod_live;
    logic [HB_NSRC-1:0]      src_rd;
    logic [HB_NSRC*RW-1:0]   src_idx;
    logic                    hit;

    assign prod_live = dec_valid && ex_valid && (ex_is_load || ex_is_spr_rd);
    // a register jump reads only its target (source B)
    assign src_rd  = {dec_rd_b, dec_rd_a && (dec_kind != KIND_JREG)};
    assign src_idx = {dec_src_b, dec_src_a};

    hb_dep_match #(.RW(RW), .NSRC(HB_NSRC)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .prod_live (prod_live),
        .prod_dst  (ex_dst),
        .src_idx   (src_idx),
        .src_rd    (src_rd),
        .hit       (hit)
    );

    hb_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .hazard      (hit),
        .dec_valid   (dec_valid),
        .dec_kind    (dec_kind),
        .mem_valid   (mem_valid),
        .mem_stall   (mem_stall),
        .issue_o     (issue_o),
        .bubble_o    (bubble_o),
        .hold_o      (hold_o),
        .div_start_o (div_start_o),
        .jump_go_o   (jump_go_o)
    );

    // R7
    div_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_start_o || jump_go_o) |-> issue_o);
endmodule

// File: tb/sim_hb_bubble_ctrl.sv
`timescale 1ns/1ps
module sim_hb_bubble_ctrl;
    localparam int RW = 5;
    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic dec_valid = 1'b0, dec_rd_a = 1'b0, dec_rd_b = 1'b0;
    logic [1:0] dec_kind = 2'b00;
    logic [RW-1:0] dec_src_a = '0, dec_src_b = '0, ex_dst = '0;
    logic ex_valid = 1'b0, ex_is_load = 1'b0, ex_is_spr_rd = 1'b0;
    logic mem_valid = 1'b0, mem_stall = 1'b0;
    logic issue_o, bubble_o, hold_o, div_start_o, jump_go_o;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    hb_bubble_ctrl #(.RW(RW)) u0 (.*);

    // outputs packed {issue, bubble, hold, div_start, jump_go}
    task automatic chk(string req, logic [4:0] exp);
        logic [4:0] got;
        got = {issue_o, bubble_o, hold_o, div_start_o, jump_go_o};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        flush = 0; dec_valid = 0; dec_kind = 2'b00; dec_rd_a = 0; dec_rd_b = 0;
        dec_src_a = 0; dec_src_b = 0; ex_valid = 0; ex_is_load = 0;
        ex_is_spr_rd = 0; ex_dst = 0; mem_valid = 0; mem_stall = 0;
    endtask

    // producer in execute, consumer in decode reading src A
    task automatic set_hazard(bit spr, logic [1:0] kind);
        dec_valid = 1; dec_kind = kind; dec_rd_a = 1; dec_src_a = 5'd3;
        ex_valid = 1; ex_is_load = !spr; ex_is_spr_rd = spr; ex_dst = 5'd3;
    endtask

    task automatic t_reset();
        idle_inputs(); #5;
        chk("R11 reset", 5'b00000);
        nxt();
    endtask

    task automatic t_nohaz();
        idle_inputs();
        dec_valid = 1; dec_rd_a = 1; dec_src_a = 5'd5;
        ex_valid = 1; ex_is_load = 1; ex_dst = 5'd6; #5;
        chk("R10 no hazard issues", 5'b10000);
        dec_valid = 0; #1;
        chk("R10 issue follows dec_valid", 5'b00000);
        nxt();
    endtask

    task automatic t_stall_run(bit spr);
        idle_inputs(); set_hazard(spr, 2'b00); #5;
        chk(spr ? "R2 spr read bubble" : "R1 load bubble", 5'b01100);
        nxt();
        ex_valid = 0; ex_is_load = 0; ex_is_spr_rd = 0;
        mem_valid = 1; mem_stall = 1; #5;
        chk("R5 wait bubble", 5'b01100);
        nxt(); #5;
        chk("R5 stall bubble", 5'b01100);
        nxt(); mem_stall = 0; #5;
        chk("R5 stall bubble last", 5'b01100);
        nxt(); mem_valid = 0; #5;
        chk(spr ? "R2 spr release" : "R6 release", 5'b10000);
        nxt(); #5;
        chk("R6 back in pass", 5'b10000);
        nxt();
    endtask

    task automatic t_r0_and_unused();
        idle_inputs(); set_hazard(0, 2'b00); dec_src_a = 0; ex_dst = 0; #5;
        chk("R3 r0 never hazards", 5'b10000);
        nxt();
        idle_inputs(); set_hazard(0, 2'b00); dec_rd_a = 0; #5;
        chk("R4 unread source ignored", 5'b10000);
        nxt();
        idle_inputs(); set_hazard(0, 2'b10); #5;
        chk("R4 jump ignores src A", 5'b10001);
        nxt();
    endtask

    task automatic t_jump_div(logic [1:0] kind);
        idle_inputs();
        dec_valid = 1; dec_kind = kind;
        if (kind == 2'b10) begin dec_rd_b = 1; dec_src_b = 5'd7; end
        else begin dec_rd_a = 1; dec_src_a = 5'd7; end
        ex_valid = 1; ex_is_load = 1; ex_dst = 5'd7; #5;
        chk("R7 held start off", 5'b01100);
        nxt(); ex_valid = 0; ex_is_load = 0; mem_valid = 1; #5;
        chk("R7 wait start off", 5'b01100);
        nxt(); mem_valid = 0; #5;
        chk("R7 release start", kind == 2'b10 ? 5'b10001 : 5'b10010);
        if (kind == 2'b10) begin
            mem_stall = 1; #2;
            chk("R9 jump steady stall high", 5'b10001);
            mem_stall = 0; #2;
            chk("R9 jump steady stall low", 5'b10001);
        end
        nxt();
    endtask

    task automatic t_flush();
        idle_inputs(); set_hazard(0, 2'b00); flush = 1; #5;
        chk("R8 flush kills bubble", 5'b00000);
        nxt(); flush = 0; ex_valid = 0; #5;
        chk("R8 pass after flush", 5'b10000);
        nxt();
        idle_inputs(); set_hazard(0, 2'b00); #5;
        chk("R1 hazard before flush", 5'b01100);
        nxt(); ex_valid = 0; mem_valid = 1; mem_stall = 1; flush = 1; #5;
        chk("R8 flush in wait", 5'b00000);
        nxt(); flush = 0; mem_valid = 0; mem_stall = 0; #5;
        chk("R8 wait discarded", 5'b10000);
        nxt();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_nohaz();
        t_stall_run(0);
        t_stall_run(1);
        t_r0_and_unused();
        t_jump_div(2'b10);
        t_jump_div(2'b01);
        t_flush();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule